// File: doc/BRIEF.md
# Snapshot Frame Controller

This block picks, for every video frame that leaves the capture pipeline, the image type that frame carries and whether it is marked as a snapshot. A snapshot can be requested in two ways. One is an active-low push-button pin, passed through a synchronizer and an optional minimum-press-width filter. The other is a write of 1 to a software snap bit in a small register port. The pipeline pulses `frame_start` once at each frame boundary. The type, snap flag and scheme flag chosen for that frame are captured on that pulse and held until the next one.

Two schemes are selected at run time. In the flag-only scheme every frame uses the programmed image type, and the frame that follows a request simply carries snap = 1. In the insertion scheme the image-type register holds two fields: a video-mode code in bits [2:0] and a still-mode code in bits [4:3]. A request lets the current frame finish. It then produces exactly one frame with the still-mode type and snap = 1, and after that video frames resume. Requests that arrive while a snapshot is already pending, or while a snapshot frame is being sent, are merged into that snapshot.

Top module: `snap_frame_ctrl`

## Requirements
- R1: After reset, `frame_type`, `frame_snap`, `frame_scheme` and `reg_rdata` are 0, and both registers read back 0.
- R2: Register 0 holds the image type in bits [4:0]. Register 1 holds the scheme select in bit 0 (0 = flag-only, 1 = insertion) and the press-width check enable in bit 2. All of these read back what was written, with `reg_rdata` valid on the cycle after `reg_rd_en`.
- R3: Writing register 1 with bit 3 = 1 raises one snapshot request. Writing it with bit 3 = 0 raises none. Bit 3 always reads as 0.
- R4: Register 1 bit 1 is set by each accepted button press and is cleared by a read of register 1. That read still returns 1.
- R5: With the width check off, each high-to-low transition of the synchronized pin counts as one press. Holding the pin low does not count again.
- R6: With the width check on, a press counts only once the synchronized pin has stayed low for HOLD_CYCLES consecutive cycles. A shorter low pulse is ignored.
- R7: The outputs `frame_type`, `frame_snap` and `frame_scheme` change only on the cycle after `frame_start`. Register writes made during a frame do not alter them.
- R8: In the flag-only scheme, `frame_type` equals register 0 bits [4:0]. The first frame started after a request has `frame_snap` = 1, and the frame after that has 0.
- R9: In the insertion scheme, a video frame has type {2'b00, code}, where a code above 5 is reported as 0. The single frame after a request has type {still code, 3'b000} and snap = 1. The next frame is a video frame again.
- R10: In the insertion scheme, while the still-mode code is 00 or 10, requests are dropped and no snapshot frame is produced.
- R11: A request made while a snapshot is pending, or during a frame with snap = 1, produces no extra snapshot frame. A snapshot frame is never directly followed by another.
- R12: A request arriving in the same cycle as `frame_start` applies to the frame after the one being started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snap_btn_n | input | 1 | Asynchronous active-low snapshot button |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 = image type, 1 = control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| frame_type | output | 5 | Image type of the current frame |
| frame_snap | output | 1 | Snapshot flag of the current frame |
| frame_scheme | output | 1 | Scheme in force for the current frame |

## Verification
A wrong pending flag becomes visible at the ports on the next `frame_start`. It shows up either as a missing snapshot frame, or as a duplicate one with a still-mode type where a video type was due, one cycle after the strobe. A wrong synchronizer or width counter shows up as a status bit that is set too early, too late, or twice. The bench sees it at the next read of register 1. Because the reference model is compared with all outputs on every cycle, any such divergence is reported in the cycle it first appears.

// File: rtl/snapfc_pkg.sv
package snapfc_pkg;
  localparam int TYPE_W     = 5;
  localparam int VID_W      = 3;
  localparam int STILL_W    = TYPE_W - VID_W;
  localparam int REG_AW     = 2;
  localparam int REG_DW     = 8;
  localparam int VID_MAX    = 5;

  localparam logic [REG_AW-1:0] ADDR_TYPE = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd1;

  localparam int CTL_SCHEME = 0;
  localparam int CTL_STAT   = 1;
  localparam int CTL_WCHK   = 2;
  localparam int CTL_SWSNAP = 3;

  typedef struct packed {
    logic [TYPE_W-1:0] img;
    logic              scheme;
    logic              wchk;
  } cfg_t;
endpackage

// File: rtl/snapfc_btn_qual.sv
module snapfc_btn_qual #(
  parameter int HOLD_CYCLES = 124800
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_n,
  input  logic chk_en,
  output logic press
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] HOLD_TOP  = CNT_W'(HOLD_CYCLES);

  logic [1:0]       sync_q;
  logic             prev_q;
  logic [CNT_W-1:0] low_cnt;
  logic             lvl_low;
  logic             fall;
  logic             held;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 2'b11;
      prev_q  <= 1'b1;
      low_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], btn_n};
      prev_q <= sync_q[1];
      if (sync_q[1])
        low_cnt <= '0;
      else if (low_cnt != HOLD_TOP)
        low_cnt <= low_cnt + 1'b1;
    end
  end

  assign lvl_low = ~sync_q[1];
  assign fall    = prev_q & lvl_low;
  assign held    = lvl_low && (low_cnt == HOLD_LAST);
  assign press   = chk_en ? held : fall;

  // R5
  one_press_per_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (press && !chk_en) |=> !(press && !chk_en));
endmodule

// File: rtl/snapfc_regs.sv
module snapfc_regs
  import snapfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              hw_press,
  output cfg_t              cfg,
  output logic              sw_req,
  output logic [REG_DW-1:0] rdata
);
  cfg_t cfg_q;
  logic stat_q;
  logic sel_type;
  logic sel_ctrl;
  logic unused_bits;

  assign sel_type    = (addr == ADDR_TYPE);
  assign sel_ctrl    = (addr == ADDR_CTRL);
  assign sw_req      = wr_en && sel_ctrl && wdata[CTL_SWSNAP];
  assign unused_bits = ^{wdata[REG_DW-1:TYPE_W], wdata[CTL_STAT]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      stat_q <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr_en && sel_type)
        cfg_q.img <= wdata[TYPE_W-1:0];
      if (wr_en && sel_ctrl) begin
        cfg_q.scheme <= wdata[CTL_SCHEME];
        cfg_q.wchk   <= wdata[CTL_WCHK];
      end
      if (hw_press)
        stat_q <= 1'b1;
      else if (rd_en && sel_ctrl)
        stat_q <= 1'b0;
      if (rd_en) begin
        rdata <= '0;
        if (sel_type)
          rdata[TYPE_W-1:0] <= cfg_q.img;
        else if (sel_ctrl) begin
          rdata[CTL_SCHEME] <= cfg_q.scheme;
          rdata[CTL_STAT]   <= stat_q;
          rdata[CTL_WCHK]   <= cfg_q.wchk;
        end
      end
    end
  end

  assign cfg = cfg_q;

  // R4
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_ctrl && !hw_press) |=> !stat_q);

  // R4
  stat_set_chk: assert property (@(posedge clk) disable iff (rst)
    hw_press |=> stat_q);
endmodule

// File: rtl/snapfc_seq.sv
module snapfc_seq
  import snapfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              req,
  input  cfg_t              cfg,
  output logic [TYPE_W-1:0] frame_type,
  output logic              frame_snap,
  output logic              frame_scheme
);
  logic [STILL_W-1:0] still_code;
  logic [VID_W-1:0]   vid_code;
  logic [VID_W-1:0]   vid_fix;
  logic               still_bad;
  logic               req_ok;
  logic               fire;
  logic               pend_q;

  assign still_code = cfg.img[TYPE_W-1:VID_W];
  assign vid_code   = cfg.img[VID_W-1:0];
  assign vid_fix    = (vid_code > VID_W'(VID_MAX)) ? '0 : vid_code;
  assign still_bad  = cfg.scheme && !still_code[0];
  assign req_ok     = req && !still_bad;
  assign fire       = pend_q && !still_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q       <= 1'b0;
      frame_type   <= '0;
      frame_snap   <= 1'b0;
      frame_scheme <= 1'b0;
    end else if (frame_start) begin
      frame_scheme <= cfg.scheme;
      frame_snap   <= fire;
      pend_q       <= req_ok && !pend_q;
      if (!cfg.scheme)
        frame_type <= cfg.img;
      else if (fire)
        frame_type <= {still_code, {VID_W{1'b0}}};
      else
        frame_type <= {{STILL_W{1'b0}}, vid_fix};
    end else begin
      pend_q <= pend_q || (req_ok && !frame_snap);
    end
  end

  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(frame_type) && $stable(frame_snap) && $stable(frame_scheme)));

  // R9
  still_type_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_snap && frame_scheme) |-> (frame_type[VID_W-1:0] == '0 && frame_type[VID_W]));

  // R9
  video_type_chk: assert property (@(posedge clk) disable iff (rst)
    (!frame_snap && frame_scheme) |-> (frame_type[TYPE_W-1:VID_W] == '0 && frame_type[VID_W-1:0] <= VID_W'(VID_MAX)));

  // R11
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && frame_snap) |=> !frame_snap);
endmodule

// File: rtl/snap_frame_ctrl.sv
module snap_frame_ctrl
  import snapfc_pkg::*;
#(
  parameter int HOLD_CYCLES = 124800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snap_btn_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              frame_start,
  output logic [TYPE_W-1:0] frame_type,
  output logic              frame_snap,
  output logic              frame_scheme
);
  cfg_t cfg;
  logic hw_press;
  logic sw_req;

  snapfc_btn_qual #(.HOLD_CYCLES(HOLD_CYCLES)) u_qual (
    .clk    (clk),
    .rst    (rst),
    .btn_n  (snap_btn_n),
    .chk_en (cfg.wchk),
    .press  (hw_press)
  );

  snapfc_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .rd_en    (reg_rd_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .hw_press (hw_press),
    .cfg      (cfg),
    .sw_req   (sw_req),
    .rdata    (reg_rdata)
  );

  snapfc_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .req          (hw_press | sw_req),
    .cfg          (cfg),
    .frame_type   (frame_type),
    .frame_snap   (frame_snap),
    .frame_scheme (frame_scheme)
  );
endmodule

// File: tb/tb_snap_frame_ctrl.sv
module tb_snap_frame_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 8;
  localparam int WDOG_LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn_n = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       fs = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [4:0] ftype;
  logic       fsnap;
  logic       fsch;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snap_frame_ctrl #(.HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst(rst), .snap_btn_n(btn_n),
    .reg_wr_en(wr_en), .reg_rd_en(rd_en), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .frame_start(fs),
    .frame_type(ftype), .frame_snap(fsnap), .frame_scheme(fsch)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model
  logic       m_p1 = 1'b1, m_p2 = 1'b1, m_p3 = 1'b1;
  int         m_run = 0;
  logic [4:0] m_img = '0;
  logic       m_scheme = 0, m_wchk = 0, m_stat = 0, m_pend = 0;
  logic [4:0] m_ftype = '0;
  logic       m_fsnap = 0, m_fsch = 0;
  logic [7:0] m_rdata = '0;

  always @(posedge clk) begin
    bit press, sw, bad, req, fire;
    int vid;
    if (rst) begin
      m_p1 = 1; m_p2 = 1; m_p3 = 1; m_run = 0;
      m_img = 0; m_scheme = 0; m_wchk = 0; m_stat = 0; m_pend = 0;
      m_ftype = 0; m_fsnap = 0; m_fsch = 0; m_rdata = 0;
    end else begin
      press = m_wchk ? (!m_p2 && m_run == HOLD - 1) : (m_p3 && !m_p2);
      sw    = wr_en && addr == 2'd1 && wdata[3];
      bad   = m_scheme && !m_img[3];
      req   = (press || sw) && !bad;
      fire  = m_pend && !bad;
      vid   = m_img[2:0];
      if (vid > 5) vid = 0;
      if (rd_en) begin
        if (addr == 2'd0) m_rdata = {3'b000, m_img};
        else if (addr == 2'd1) m_rdata = {5'b00000, m_wchk, m_stat, m_scheme};
        else m_rdata = 8'h00;
      end
      if (press) m_stat = 1;
      else if (rd_en && addr == 2'd1) m_stat = 0;
      if (fs) begin
        m_fsch = m_scheme;
        if (!m_scheme) m_ftype = m_img;
        else if (fire) m_ftype = {m_img[4:3], 3'b000};
        else m_ftype = 5'(vid);
        m_fsnap = fire;
        m_pend  = req && !m_pend;
      end else begin
        m_pend = m_pend || (req && !m_fsnap);
      end
      if (wr_en && addr == 2'd0) m_img = wdata[4:0];
      if (wr_en && addr == 2'd1) begin m_scheme = wdata[0]; m_wchk = wdata[2]; end
      if (m_p2) m_run = 0;
      else if (m_run < HOLD) m_run++;
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = btn_n;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R8 model frame_type", ftype, m_ftype);
      chk("R11 model frame_snap", fsnap, m_fsnap);
      chk("R7 model frame_scheme", fsch, m_fsch);
      chk("R2 model reg_rdata", rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_LIMIT) begin
      checks++; errors++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, WDOG_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic frame();
    @(negedge clk); fs = 1;
    @(negedge clk); fs = 0;
  endtask

  task automatic frame_with_sw(input logic [7:0] d);
    @(negedge clk); fs = 1; wr_en = 1; addr = 2'd1; wdata = d;
    @(negedge clk); fs = 0; wr_en = 0;
  endtask

  task automatic hold_low(input int n);
    @(negedge clk); btn_n = 0;
    step(n);
    btn_n = 1;
    step(5);
  endtask

  initial begin
    logic [7:0] v;
    step(3);
    rst = 0;
    step(1);
    // R1 reset state
    chk("R1 frame_type", ftype, 0);
    chk("R1 frame_snap", fsnap, 0);
    chk("R1 frame_scheme", fsch, 0);
    rd(2'd0, v); chk("R1 type reg", v, 0);
    rd(2'd1, v); chk("R1 ctrl reg", v, 0);

    // R2 register readback, flag-only scheme with type 2
    wr(2'd0, 8'h02);
    rd(2'd0, v); chk("R2 type readback", v, 2);
    frame();
    chk("R8 flag-only type", ftype, 2);
    chk("R8 no snap", fsnap, 0);
    chk("R7 scheme bit", fsch, 0);

    // R3 software snap
    wr(2'd1, 8'h08);
    rd(2'd1, v); chk("R3 sw bit reads 0", v, 0);
    frame(); chk("R8 snap after sw", fsnap, 1); chk("R8 type kept", ftype, 2);
    frame(); chk("R8 snap cleared", fsnap, 0);
    wr(2'd1, 8'h00);
    frame(); chk("R3 write 0 no effect", fsnap, 0);

    // R4/R5 button with width check off
    @(negedge clk); btn_n = 0;
    step(6);
    rd(2'd1, v); chk("R4 status set", v, 2);
    step(6);
    rd(2'd1, v); chk("R5 no retrigger while held", v, 0);
    btn_n = 1; step(4);
    frame(); chk("R5 press flags frame", fsnap, 1);
    frame(); chk("R5 single flag", fsnap, 0);

    // R6 width check
    wr(2'd1, 8'h04);
    hold_low(HOLD - 3);
    rd(2'd1, v); chk("R6 short press ignored", v, 4);
    frame(); chk("R6 short press no snap", fsnap, 0);
    hold_low(HOLD + 6);
    rd(2'd1, v); chk("R6 long press counted", v, 6);
    frame(); chk("R6 long press snap", fsnap, 1);
    frame();

    // R9 insertion scheme: video code 4, still code 01
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h0C);
    frame(); chk("R9 video type", ftype, 4); chk("R9 video snap", fsnap, 0); chk("R7 scheme 1", fsch, 1);
    wr(2'd1, 8'h09);
    frame(); chk("R9 still type", ftype, 8); chk("R9 still snap", fsnap, 1);
    frame(); chk("R9 back to video", ftype, 4); chk("R9 video again", fsnap, 0);

    // R11 merging
    wr(2'd1, 8'h09); wr(2'd1, 8'h09);
    frame(); chk("R11 merged still", fsnap, 1);
    wr(2'd1, 8'h09);
    frame(); chk("R11 during still dropped", fsnap, 0);
    frame(); chk("R11 no extra still", fsnap, 0);

    // R12 request on frame boundary
    frame_with_sw(8'h09);
    chk("R12 current frame not still", fsnap, 0);
    frame(); chk("R12 next frame still", fsnap, 1); chk("R12 still type", ftype, 8);
    frame(); chk("R12 video resumes", fsnap, 0);

    // R10 reserved still code 10
    wr(2'd0, 8'h11);
    wr(2'd1, 8'h09);
    frame(); chk("R10 type", ftype, 1); chk("R10 no still", fsnap, 0);
    frame(); chk("R10 still none later", fsnap, 0);

    // R9 reserved video code, still code 11
    wr(2'd0, 8'h1F);
    frame(); chk("R9 reserved video as 0", ftype, 0);
    wr(2'd1, 8'h09);
    frame(); chk("R9 still code 11", ftype, 24); chk("R9 still flag", fsnap, 1);

    // R7 mid-frame write holds outputs
    wr(2'd0, 8'h0B);
    step(2);
    chk("R7 type held", ftype, 24);
    chk("R7 snap held", fsnap, 1);
    frame(); chk("R7 new type at boundary", ftype, 3);

    step(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule